// File: doc/BRIEF.md
# Block-Copy Engine with Object-Table and General Transfers

This block copies bytes across an 8-bit system bus on its own, while the processor waits. It has two ways to start a copy, each set off by a single register write. The object-table copy takes a page number. It moves 160 consecutive bytes from the start of that page into a fixed attribute area at 0xFE00. The general transfer uses a 16-bit source pointer and a 16-bit destination pointer, each loaded one byte at a time. A control write then gives the length in 16-byte units and starts the copy.

Each byte is read from the bus and then written back. Both strobes are held until the bus acknowledges them. Every byte fills a fixed pacing slot of clock cycles. A general transfer's slot doubles when the double-speed input is high at its start. While a copy runs, the engine holds a stall output high and ignores all further register writes. The control register reads back the remaining length as a unit count minus one, so it reads 0xFF once a transfer has finished.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset the engine is idle: `cpu_stall`, `bus_rd` and `bus_wr` are low, and a read of register 0x55 returns 0xFF.
- R2: A write of value V to register 0x46 copies 160 bytes. For n = 0 to 159 in ascending order, it reads address {V, n} and then writes that byte to address 0xFE00 + n.
- R3: An object-table copy holds `cpu_stall` high from the cycle after the start write for exactly 4 cycles per byte (640 cycles), whatever the speed input, as long as the bus acknowledges within 1 wait cycle.
- R4: Registers 0x51 and 0x52 load the high and low bytes of the source pointer. Registers 0x53 and 0x54 load the high and low bytes of the destination pointer.
- R5: A write to register 0x55 with bit 7 = 0 starts a general transfer of (bits[6:0] + 1) × 16 bytes. Byte k is read from source + k and written to destination + k, with addresses wrapping at 16 bits.
- R6: A general-transfer byte takes a slot of 4 cycles, or 8 cycles if `double_speed` was high in the start cycle.
- R7: A read of register 0x55 returns ((remaining bytes >> 4) − 1) truncated to 8 bits, and it updates as each byte completes. Reads of any other address return 0x00.
- R8: When a general transfer ends, the length reads 0xFF and the two pointers rest at their end addresses. A further write to 0x55 therefore continues from where the last copy stopped.
- R9: A write to register 0x55 with bit 7 = 1 stores the mode and the length (readback = bits[6:0]) but starts nothing. No bus strobe follows and the stall stays low.
- R10: While `cpu_stall` is high, writes to all engine registers (0x46, 0x51 to 0x55) are ignored.
- R11: A read strobe and a write strobe are never high together. Each is held with a stable address until `bus_ack`. Bus wait states stretch a byte to max(slot, 2 + 2 × wait) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (low byte of the I/O address) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| double_speed | input | 1 | Doubles the general-transfer slot when sampled high at start |
| cpu_stall | output | 1 | High while a copy runs |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Bus acknowledge for the current strobe |

## Verification
A start write that is sampled at edge E0 raises the stall at E0. The first read strobe appears in the cycle that follows, and the stall falls at edge E0 + bytes × slot. The bench therefore counts the stall-high samples taken at the falling edges after the start and compares that count with bytes × max(slot, 2 + 2 × wait). The length readback changes at the edge that ends each byte: it still shows the starting value for the four samples up to E4 and shows the first decrement from the sample after E4. The bench reads it at exactly those two points. Bus reads and writes are compared address by address as they are acknowledged, each against the address and data that the requirement predicts.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Register decode: low byte of the I/O address
    localparam logic [7:0] RA_OBJ_PAGE = 8'h46;
    localparam logic [7:0] RA_SRC_HI   = 8'h51;
    localparam logic [7:0] RA_SRC_LO   = 8'h52;
    localparam logic [7:0] RA_DST_HI   = 8'h53;
    localparam logic [7:0] RA_DST_LO   = 8'h54;
    localparam logic [7:0] RA_GP_CTRL  = 8'h55;

    // High byte of the object attribute area
    localparam logic [7:0] OBJ_AREA_HI = 8'hFE;

    typedef enum logic {
        XFER_OBJ = 1'b0,
        XFER_GP  = 1'b1
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_PACE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       obj_go;
        logic       gp_go;
        logic [7:0] page;
    } start_req_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Remaining byte count to the register's unit-minus-one code
    function automatic logic [7:0] length_code(input logic [15:0] rem, input int unit_shift);
        logic [15:0] units;
        units = rem >> unit_shift;
        return 8'(units - 16'd1);
    endfunction

    // Byte slot length for a transfer kind and speed
    function automatic logic [7:0] slot_for(input xfer_kind_e kind, input logic dbl,
                                            input logic [7:0] base);
        if (kind == XFER_GP && dbl)
            return base << 1;
        return base;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int CTRL_LEN_W = 7,
    parameter int UNIT_SHIFT = 4,
    parameter int LEN_W      = CTRL_LEN_W + UNIT_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              step,
    output start_req_t        start,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [LEN_W-1:0]  rem,
    output logic              mode_q,
    output logic [7:0]        rdata
);

    logic wr_ok;
    logic [LEN_W-1:0] len_load;

    assign wr_ok    = we && !busy;
    assign len_load = (LEN_W'(wdata[CTRL_LEN_W-1:0]) + LEN_W'(1)) << UNIT_SHIFT;

    always_comb begin
        start.obj_go = wr_ok && (addr == RA_OBJ_PAGE);
        start.gp_go  = wr_ok && (addr == RA_GP_CTRL) && !wdata[7];
        start.page   = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src    <= '0;
            dst    <= '0;
            rem    <= '0;
            mode_q <= 1'b0;
        end else if (wr_ok) begin
            case (addr)
                RA_SRC_HI:  src[15:8] <= wdata;
                RA_SRC_LO:  src[7:0]  <= wdata;
                RA_DST_HI:  dst[15:8] <= wdata;
                RA_DST_LO:  dst[7:0]  <= wdata;
                RA_GP_CTRL: begin
                    mode_q <= wdata[7];
                    rem    <= len_load;
                end
                default: ;
            endcase
        end else if (step) begin
            src <= src + 1'b1;
            dst <= dst + 1'b1;
            rem <= rem - 1'b1;
        end
    end

    always_comb begin
        if (addr == RA_GP_CTRL)
            rdata = length_code(16'(rem), UNIT_SHIFT);
        else
            rdata = 8'h00;
    end

endmodule

// File: rtl/dma_pacer.sv
module dma_pacer #(
    parameter int PACE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PACE_W-1:0] load_len,
    input  logic              restart,
    input  logic              active,
    output logic              slot_last
);

    localparam logic [PACE_W-1:0] CNT_MAX = '1;

    logic [PACE_W-1:0] slot_len;
    logic [PACE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_len <= '0;
            cnt      <= '0;
        end else begin
            if (load)
                slot_len <= load_len;
            if (restart)
                cnt <= '0;
            else if (active && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    assign slot_last = (cnt >= slot_len - 1'b1);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int OBJ_BYTES = 160,
    parameter int IDX_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  start_req_t        start,
    input  logic [ADDR_W-1:0] gp_src,
    input  logic [ADDR_W-1:0] gp_dst,
    input  logic              gp_last,
    input  logic              slot_last,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output bus_req_t          bus,
    output logic              busy,
    output xfer_kind_e        kind,
    output logic              byte_done,
    output logic              restart
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OBJ_BYTES - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        page;
    logic [DATA_W-1:0] data_q;
    logic              finish;
    logic              is_last;

    always_comb begin
        finish  = ((state == SQ_WRITE) && bus_ack && slot_last) ||
                  ((state == SQ_PACE) && slot_last);
        is_last = (kind == XFER_OBJ) ? (idx == IDX_LAST) : gp_last;
        restart = ((state == SQ_IDLE) && (start.obj_go || start.gp_go)) ||
                  (finish && !is_last);
        byte_done = finish;
        busy      = (state != SQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            idx    <= '0;
            page   <= '0;
            kind   <= XFER_OBJ;
            data_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start.obj_go) begin
                        state <= SQ_READ;
                        kind  <= XFER_OBJ;
                        page  <= start.page;
                        idx   <= '0;
                    end else if (start.gp_go) begin
                        state <= SQ_READ;
                        kind  <= XFER_GP;
                        idx   <= '0;
                    end
                end
                SQ_READ: begin
                    if (bus_ack) begin
                        data_q <= bus_rdata;
                        state  <= SQ_WRITE;
                    end
                end
                SQ_WRITE, SQ_PACE: begin
                    if (finish) begin
                        if (is_last) begin
                            state <= SQ_IDLE;
                        end else begin
                            state <= SQ_READ;
                            idx   <= idx + 1'b1;
                        end
                    end else if (state == SQ_WRITE && bus_ack) begin
                        state <= SQ_PACE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        bus = '0;
        case (state)
            SQ_READ: begin
                bus.rd   = 1'b1;
                bus.addr = (kind == XFER_OBJ) ? {page, 8'(idx)} : gp_src;
            end
            SQ_WRITE: begin
                bus.wr    = 1'b1;
                bus.addr  = (kind == XFER_OBJ) ? {OBJ_AREA_HI, 8'(idx)} : gp_dst;
                bus.wdata = data_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import dma_pkg::*;
#(
    parameter int OBJ_BYTES   = 160,
    parameter int SLOT_CYCLES = 4,
    parameter int CTRL_LEN_W  = 7,
    parameter int UNIT_SHIFT  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        double_speed,
    output logic        cpu_stall,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic        bus_ack
);

    localparam int LEN_W  = CTRL_LEN_W + UNIT_SHIFT + 1;
    localparam int PACE_W = $clog2(SLOT_CYCLES * 2) + 2;
    localparam int IDX_W  = $clog2(OBJ_BYTES);

    start_req_t        start_w;
    bus_req_t          bus_w;
    logic [ADDR_W-1:0] gp_src_w;
    logic [ADDR_W-1:0] gp_dst_w;
    logic [LEN_W-1:0]  rem_w;
    logic              mode_w;
    logic              busy_w;
    xfer_kind_e        kind_w;
    logic              byte_done_w;
    logic              restart_w;
    logic              slot_last_w;
    logic              step_w;
    logic              load_w;
    logic [PACE_W-1:0] load_len_w;

    assign step_w     = byte_done_w && (kind_w == XFER_GP);
    assign load_w     = start_w.obj_go || start_w.gp_go;
    assign load_len_w = PACE_W'(slot_for(start_w.gp_go ? XFER_GP : XFER_OBJ,
                                         double_speed, 8'(SLOT_CYCLES)));

    dma_regs #(
        .CTRL_LEN_W (CTRL_LEN_W),
        .UNIT_SHIFT (UNIT_SHIFT),
        .LEN_W      (LEN_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy_w),
        .step   (step_w),
        .start  (start_w),
        .src    (gp_src_w),
        .dst    (gp_dst_w),
        .rem    (rem_w),
        .mode_q (mode_w),
        .rdata  (reg_rdata)
    );

    dma_pacer #(
        .PACE_W (PACE_W)
    ) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .load_len  (load_len_w),
        .restart   (restart_w),
        .active    (busy_w),
        .slot_last (slot_last_w)
    );

    dma_seq #(
        .OBJ_BYTES (OBJ_BYTES),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .gp_src    (gp_src_w),
        .gp_dst    (gp_dst_w),
        .gp_last   (rem_w == LEN_W'(1)),
        .slot_last (slot_last_w),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus       (bus_w),
        .busy      (busy_w),
        .kind      (kind_w),
        .byte_done (byte_done_w),
        .restart   (restart_w)
    );

    assign cpu_stall = busy_w;
    assign bus_rd    = bus_w.rd;
    assign bus_wr    = bus_w.wr;
    assign bus_addr  = bus_w.addr;
    assign bus_wdata = bus_w.wdata;

endmodule

// File: rtl/dma_chk.sv
module dma_chk
    import dma_pkg::*;
#(
    parameter int OBJ_BYTES = 160,
    parameter int LEN_W     = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             cpu_stall,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [15:0]      bus_addr,
    input logic             bus_ack,
    input xfer_kind_e       kind,
    input logic [15:0]      gp_src,
    input logic [LEN_W-1:0] rem
);

    // R11
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr)));

    // R2
    obj_window_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && kind == XFER_OBJ) |->
            (bus_addr[15:8] == OBJ_AREA_HI && bus_addr[7:0] < 8'(OBJ_BYTES)));

    // R3
    stall_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> cpu_stall);

    // R8
    gp_len_live_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && kind == XFER_GP) |-> (rem != '0));

    // R9
    hold_mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && reg_we && reg_addr == RA_GP_CTRL && reg_wdata[7]) |=> !cpu_stall);

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && kind == XFER_OBJ && reg_we) |=> ($stable(gp_src) && $stable(rem)));

endmodule

bind dma_copy_engine dma_chk #(
    .OBJ_BYTES (OBJ_BYTES),
    .LEN_W     (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cpu_stall (cpu_stall),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_ack   (bus_ack),
    .kind      (kind_w),
    .gp_src    (gp_src_w),
    .rem       (rem_w)
);

// File: tb/sim_dma_copy_engine.sv
`timescale 1ns/1ps
module sim_dma_copy_engine;

    typedef struct packed {
        logic        gp;
        logic        dbl;
        logic [1:0]  ws;
        logic [7:0]  page;
        logic [15:0] src;
        logic [15:0] dst;
        logic [6:0]  units;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 2'd0, 8'hC1, 16'h0000, 16'h0000, 7'd0},
        '{1'b0, 1'b1, 2'd0, 8'h80, 16'h0000, 16'h0000, 7'd0},
        '{1'b1, 1'b0, 2'd0, 8'h00, 16'h1234, 16'h8000, 7'd0},
        '{1'b1, 1'b1, 2'd0, 8'h00, 16'hA0F8, 16'h9FF0, 7'd2},
        '{1'b1, 1'b0, 2'd2, 8'h00, 16'h4000, 16'h8800, 7'd1},
        '{1'b1, 1'b1, 2'd2, 8'h00, 16'hFFF8, 16'hD000, 7'd0},
        '{1'b1, 1'b0, 2'd0, 8'h00, 16'h0000, 16'hC000, 7'h7F},
        '{1'b0, 1'b0, 2'd1, 8'h07, 16'h0000, 16'h0000, 7'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        double_speed = 1'b0;
    logic        cpu_stall;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_ack;

    logic [1:0]  ws = 2'd0;
    logic [1:0]  wcnt = 2'd0;

    int errors = 0;
    int checks = 0;

    // monitor expectations
    logic        m_gp = 1'b0;
    logic [7:0]  m_page = 8'h00;
    logic [15:0] m_src = 16'h0;
    logic [15:0] m_dst = 16'h0;
    int          m_rd = 0;
    int          m_wr = 0;
    int          m_bad = 0;
    int          m_any = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    function automatic logic [15:0] exp_src(input int k);
        return m_gp ? (m_src + 16'(k)) : {m_page, 8'(k)};
    endfunction

    function automatic logic [15:0] exp_dst(input int k);
        return m_gp ? (m_dst + 16'(k)) : {8'hFE, 8'(k)};
    endfunction

    assign bus_ack   = (bus_rd || bus_wr) && (wcnt == ws);
    assign bus_rdata = pat(bus_addr);

    always @(posedge clk) begin
        if (rst || !(bus_rd || bus_wr) || bus_ack) wcnt <= 2'd0;
        else wcnt <= wcnt + 2'd1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd || bus_wr) m_any = m_any + 1;
            if (bus_rd && bus_ack) begin
                if (bus_addr != exp_src(m_rd)) m_bad = m_bad + 1;
                m_rd = m_rd + 1;
            end
            if (bus_wr && bus_ack) begin
                if (bus_addr != exp_dst(m_wr) || bus_wdata != pat(exp_src(m_wr)))
                    m_bad = m_bad + 1;
                m_wr = m_wr + 1;
            end
        end
    end

    dma_copy_engine u0 (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .double_speed (double_speed),
        .cpu_stall    (cpu_stall),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_ack      (bus_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic arm(input logic gp, input logic [7:0] pg, input logic [15:0] s,
                       input logic [15:0] d);
        m_gp = gp; m_page = pg; m_src = s; m_dst = d;
        m_rd = 0; m_wr = 0; m_bad = 0; m_any = 0;
    endtask

    task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
        wr_reg(8'h51, s[15:8]);
        wr_reg(8'h52, s[7:0]);
        wr_reg(8'h53, d[15:8]);
        wr_reg(8'h54, d[7:0]);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cpu_stall && n < 40000) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(cpu_stall == 1'b0, "R1 stall", int'(cpu_stall), 0);
        chk(!bus_rd && !bus_wr, "R1 strobes", int'({bus_rd, bus_wr}), 0);
        rd_reg(8'h55, rv);
        chk(rv == 8'hFF, "R1 length", int'(rv), 8'hFF);
        rd_reg(8'h46, rv);
        chk(rv == 8'h00, "R7 other addr", int'(rv), 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            automatic vec_t v = VEC[i];
            automatic int bytes = v.gp ? (int'(v.units) + 1) * 16 : 160;
            automatic int slot = (v.gp && v.dbl) ? 8 : 4;
            automatic int hs = 2 + 2 * int'(v.ws);
            automatic int exp_cyc = bytes * ((slot > hs) ? slot : hs);
            ws = v.ws;
            double_speed = v.dbl;
            arm(v.gp, v.page, v.src, v.dst);
            if (v.gp) begin
                set_ptrs(v.src, v.dst);              // R4
                wr_reg(8'h55, {1'b0, v.units});      // R5
            end else begin
                wr_reg(8'h46, v.page);               // R2
            end
            wait_idle(n);
            if (v.gp)
                chk(n == exp_cyc, "R6 busy cycles", n, exp_cyc);
            else
                chk(n == exp_cyc, "R3 busy cycles", n, exp_cyc);
            chk(m_bad == 0 && m_wr == bytes && m_rd == bytes,
                v.gp ? "R5 R4 stream" : "R2 stream", m_wr + 1000000 * m_bad, bytes);
            rd_reg(8'h55, rv);
            chk(rv == 8'hFF, "R8 length done", int'(rv), 8'hFF);
        end
        ws = 2'd0;
        double_speed = 1'b0;

        // R7 live readback: 48 bytes, slot 4
        arm(1'b1, 8'h00, 16'h3000, 16'h8400);
        set_ptrs(16'h3000, 16'h8400);
        wr_reg(8'h55, 8'h02);
        rd_reg(8'h55, rv);
        chk(rv == 8'h02, "R7 start code", int'(rv), 2);
        rd_reg(8'h46, rv);
        chk(rv == 8'h00, "R7 other addr busy", int'(rv), 0);
        repeat (3) @(negedge clk);
        rd_reg(8'h55, rv);
        chk(rv == 8'h02, "R7 before first byte", int'(rv), 2);
        @(negedge clk);
        rd_reg(8'h55, rv);
        chk(rv == 8'h01, "R7 after first byte", int'(rv), 1);
        wait_idle(n);
        chk(m_bad == 0 && m_wr == 48, "R7 stream", m_wr, 48);

        // R8 first half of a continued copy
        arm(1'b1, 8'h00, 16'h2000, 16'h8100);
        set_ptrs(16'h2000, 16'h8100);
        wr_reg(8'h55, 8'h00);
        wait_idle(n);
        chk(m_bad == 0 && m_wr == 16, "R8 first part", m_wr, 16);

        // R10 writes during an object copy are ignored
        arm(1'b0, 8'h30, 16'h0, 16'h0);
        wr_reg(8'h46, 8'h30);
        wr_reg(8'h51, 8'hEE);
        wr_reg(8'h55, 8'h05);
        wr_reg(8'h46, 8'h40);
        wait_idle(n);
        repeat (8) @(negedge clk);
        chk(m_bad == 0 && m_wr == 160 && !cpu_stall, "R10 no restart", m_wr, 160);
        rd_reg(8'h55, rv);
        chk(rv == 8'hFF, "R10 length untouched", int'(rv), 8'hFF);

        // R8 continuation from the end pointers (R10: 0x51 write was dropped)
        arm(1'b1, 8'h00, 16'h2010, 16'h8110);
        wr_reg(8'h55, 8'h00);
        wait_idle(n);
        chk(m_bad == 0 && m_wr == 16, "R8 R10 continuation", m_wr + 1000000 * m_bad, 16);

        // R9 hold-mode write
        arm(1'b1, 8'h00, 16'h0, 16'h0);
        wr_reg(8'h55, 8'h83);
        chk(cpu_stall == 1'b0, "R9 no stall", int'(cpu_stall), 0);
        repeat (6) @(negedge clk);
        chk(m_any == 0, "R9 no bus activity", m_any, 0);
        rd_reg(8'h55, rv);
        chk(rv == 8'h03, "R9 length latched", int'(rv), 3);
        wr_reg(8'h55, 8'hFF);
        rd_reg(8'h55, rv);
        chk(rv == 8'h7F && !cpu_stall, "R9 max length latched", int'(rv), 8'h7F);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule